// File: doc/BRIEF.md
# Endpoint Inbound Packet Classifier

This block sits at the receive side of a PCI Express endpoint and looks at one decoded transaction-layer header per cycle. For each header it makes one routing decision. The header can go to the request path, which serves memory, I/O and configuration accesses. It can go to the completion path, which returns answers to requests the endpoint issued earlier. It can be discarded. Or the block can answer it at once with a completion that carries only a status. When a memory or I/O request hits a base address register, the block also reports which register was hit and how many address bits that register decodes.

The block learns the endpoint's bus number from Type 0 configuration requests addressed to its device. It then uses that bus number to claim incoming completions. Each class of packet has its own rule for what happens when nothing matches. A posted memory write is never answered. Reads and I/O accesses get an Unsupported Request status. Configuration accesses that arrive while configuration is disabled get a Retry status. Handling of the payload and the configuration register file are outside this block.

Top module: `ep_rx_router`

## Requirements
- R1: A decision appears on the outputs exactly one clock after the header is presented, with `o_valid` high for that one cycle only. After reset `o_valid` is 0 and the captured bus number is 0.
- R2: A Type 0 configuration read (format/type 0x04) or write (0x44) whose device number equals `i_dev_num` stores the bus field of `i_rid` as the endpoint's bus number, but only while `i_cfg_en` is 1. No other header changes the stored bus number. If the function is also below NUM_FUNC, the route is 0 (request path).
- R3: While configuration is enabled, a Type 0 configuration request whose device does not match, or whose function is NUM_FUNC or more, gets route 3 (respond) with status 3'b001 (Unsupported Request).
- R4: While `i_cfg_en` is 0, a Type 0 configuration request gets route 3 with status 3'b010 (Retry) and leaves the bus number unchanged.
- R5: A Type 1 configuration request (0x05 or 0x45) gets route 2 (drop).
- R6: A completion (0x0A, 0x4A, 0x0B or 0x4B) whose requester ID carries the stored bus, `i_dev_num` and a function below NUM_FUNC gets route 1 (completion path). `o_bad_status` is 1 exactly when `i_cpl_status` is non-zero.
- R7: A completion whose requester bus, device or function does not match gets route 2, and no response is generated for it.
- R8: Memory requests (reads 0x00, 0x20, 0x01, 0x21 and writes 0x40, 0x60) are compared only against memory BARs (bit 0 = 0). I/O requests (0x02 read, 0x42 write) are compared only against I/O BARs (bit 0 = 1). A BAR whose mask is zero never matches. A hit gives route 0 and the lowest matching BAR index.
- R9: A memory write that hits no BAR gets route 2. A memory read or I/O request that hits no BAR gets route 3 with status 3'b001.
- R10: On a hit, `o_aperture` is the bit length of the inverted mask: 32 bits for a 32-bit BAR, or 64 bits formed from the mask pair of a 64-bit BAR.
- R11: A memory BAR with bits [2:1] = 2'b10 is 64-bit. It is compared over all 64 address bits, using the next BAR as the upper half, and that next BAR is never matched on its own.
- R12: Any other format/type code gets route 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_hdr_valid | input | 1 | Header present this cycle |
| i_fmt_type | input | 8 | Format (bits 7:5) and type (bits 4:0) |
| i_rid | input | 16 | Destination ID for configuration, requester ID for completions: bus[15:8], device[7:3], function[2:0] |
| i_addr | input | 64 | Request address |
| i_cpl_status | input | 3 | Completion status field |
| i_cfg_en | input | 1 | Configuration access enabled |
| i_dev_num | input | 5 | Local device number |
| i_bar_base | input | 32*NUM_BARS | BAR registers, BAR i at bits [32i+31:32i] |
| i_bar_mask | input | 32*NUM_BARS | BAR size masks, same layout |
| o_valid | output | 1 | Decision valid |
| o_route | output | 2 | 0 request, 1 completion, 2 drop, 3 respond |
| o_status | output | 3 | Status for route 3: 3'b001 UR, 3'b010 Retry |
| o_bar_idx | output | $clog2(NUM_BARS) | Hit BAR index |
| o_aperture | output | 7 | Decoded address bits of the hit BAR |
| o_bad_status | output | 1 | Claimed completion has non-success status |
| o_bus_num | output | 8 | Captured bus number |

## Verification
The checker watches, on every cycle, the one-cycle valid timing, the Retry answer while configuration is off, the drop of Type 1 requests, the rule that a memory write is never answered, the holding of the bus number, and the restriction of the bad-status flag to claimed completions. Other behaviour depends on the BAR contents and on the bus number learned earlier, so only the bench's scenarios show it. This covers lowest-index priority between overlapping BARs, the separation of I/O and memory BARs, the 64-bit pairing and its unmatched upper half, the aperture widths, and the claiming of completions against a bus learned from an earlier header.

// File: rtl/epr_pkg.sv
package epr_pkg;

    typedef enum logic [1:0] {
        ROUTE_REQ  = 2'd0,
        ROUTE_CPL  = 2'd1,
        ROUTE_DROP = 2'd2,
        ROUTE_RESP = 2'd3
    } route_e;

    typedef enum logic [2:0] {
        K_MRD, K_MWR, K_IORD, K_IOWR, K_CFG0, K_CFG1, K_CPL, K_OTHER
    } kind_e;

    localparam logic [2:0] ST_SC  = 3'b000;
    localparam logic [2:0] ST_UR  = 3'b001;
    localparam logic [2:0] ST_CRS = 3'b010;

    typedef struct packed {
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
    } pid_t;

    function automatic kind_e classify(input logic [7:0] ft);
        case (ft)
            8'h00, 8'h20, 8'h01, 8'h21: classify = K_MRD;
            8'h40, 8'h60:               classify = K_MWR;
            8'h02:                      classify = K_IORD;
            8'h42:                      classify = K_IOWR;
            8'h04, 8'h44:               classify = K_CFG0;
            8'h05, 8'h45:               classify = K_CFG1;
            8'h0A, 8'h4A, 8'h0B, 8'h4B: classify = K_CPL;
            default:                    classify = K_OTHER;
        endcase
    endfunction

    function automatic logic [6:0] bit_len64(input logic [63:0] v);
        logic [6:0] n;
        n = '0;
        for (int k = 0; k < 64; k++)
            if (v[k]) n = 7'(k + 1);
        return n;
    endfunction

endpackage

// File: rtl/epr_bar_match.sv
module epr_bar_match
    import epr_pkg::*;
#(
    parameter int NUM_BARS = 6,
    localparam int IDX_W   = $clog2(NUM_BARS)
) (
    input  logic [63:0]            addr,
    input  logic                   want_io,
    input  logic [32*NUM_BARS-1:0] bar_base,
    input  logic [32*NUM_BARS-1:0] bar_mask,
    output logic                   hit,
    output logic [IDX_W-1:0]       idx,
    output logic [6:0]             aperture
);

    logic        prev_wide;
    logic        skip, is_io, wide, kind_ok, match;
    logic [31:0] lo_b, lo_m, hi_b, hi_m;
    logic [63:0] m64, b64;

    always_comb begin
        hit       = 1'b0;
        idx       = '0;
        aperture  = '0;
        prev_wide = 1'b0;
        skip = 1'b0; is_io = 1'b0; wide = 1'b0; kind_ok = 1'b0; match = 1'b0;
        lo_b = '0; lo_m = '0; hi_b = '0; hi_m = '0; m64 = '0; b64 = '0;
        for (int i = 0; i < NUM_BARS; i++) begin
            lo_b  = bar_base[i*32 +: 32];
            lo_m  = bar_mask[i*32 +: 32];
            hi_b  = bar_base[((i + 1 < NUM_BARS) ? i + 1 : i)*32 +: 32];
            hi_m  = bar_mask[((i + 1 < NUM_BARS) ? i + 1 : i)*32 +: 32];
            skip  = prev_wide;
            is_io = lo_b[0];
            wide  = !is_io && (lo_b[2:1] == 2'b10) && (i + 1 < NUM_BARS);
            prev_wide = wide && !skip;
            if (wide) begin
                m64 = {hi_m, lo_m};
                b64 = {hi_b, lo_b & 32'hFFFF_FFF0};
            end else begin
                m64 = {32'hFFFF_FFFF, lo_m};
                b64 = {32'h0, is_io ? (lo_b & 32'hFFFF_FFFC) : (lo_b & 32'hFFFF_FFF0)};
            end
            kind_ok = (is_io == want_io) && (lo_m != 32'h0);
            match   = !skip && kind_ok && ((addr & m64) == (b64 & m64));
            if (match && !hit) begin
                hit      = 1'b1;
                idx      = IDX_W'(i);
                aperture = bit_len64(~m64);
            end
        end
    end

endmodule

// File: rtl/epr_bus_track.sv
module epr_bus_track (
    input  logic       clk,
    input  logic       rst,
    input  logic       cap_en,
    input  logic [7:0] cap_bus,
    output logic [7:0] bus_q
);

    always_ff @(posedge clk) begin
        if (rst)         bus_q <= 8'h00;
        else if (cap_en) bus_q <= cap_bus;
    end

endmodule

// File: rtl/ep_rx_router.sv
module ep_rx_router
    import epr_pkg::*;
#(
    parameter int NUM_BARS = 6,
    parameter int NUM_FUNC = 2,
    localparam int IDX_W   = $clog2(NUM_BARS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   i_hdr_valid,
    input  logic [7:0]             i_fmt_type,
    input  logic [15:0]            i_rid,
    input  logic [63:0]            i_addr,
    input  logic [2:0]             i_cpl_status,
    input  logic                   i_cfg_en,
    input  logic [4:0]             i_dev_num,
    input  logic [32*NUM_BARS-1:0] i_bar_base,
    input  logic [32*NUM_BARS-1:0] i_bar_mask,
    output logic                   o_valid,
    output logic [1:0]             o_route,
    output logic [2:0]             o_status,
    output logic [IDX_W-1:0]       o_bar_idx,
    output logic [6:0]             o_aperture,
    output logic                   o_bad_status,
    output logic [7:0]             o_bus_num
);

    kind_e            kind;
    pid_t             rid;
    logic             dev_ok, fn_ok, want_io, bar_hit, cap_en;
    logic [IDX_W-1:0] bar_idx;
    logic [6:0]       bar_ap;
    route_e           route_d;
    logic [2:0]       status_d;
    logic             bad_d, use_bar;

    assign kind    = classify(i_fmt_type);
    assign rid     = pid_t'(i_rid);
    assign dev_ok  = (rid.dev == i_dev_num);
    assign fn_ok   = (int'(rid.fn) < NUM_FUNC);
    assign want_io = (kind == K_IORD) || (kind == K_IOWR);
    assign cap_en  = i_hdr_valid && (kind == K_CFG0) && i_cfg_en && dev_ok;

    epr_bar_match #(.NUM_BARS(NUM_BARS)) u_bar (
        .addr     (i_addr),
        .want_io  (want_io),
        .bar_base (i_bar_base),
        .bar_mask (i_bar_mask),
        .hit      (bar_hit),
        .idx      (bar_idx),
        .aperture (bar_ap)
    );

    epr_bus_track u_bus (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (cap_en),
        .cap_bus (rid.bus),
        .bus_q   (o_bus_num)
    );

    always_comb begin
        route_d  = ROUTE_DROP;
        status_d = ST_SC;
        bad_d    = 1'b0;
        use_bar  = 1'b0;
        case (kind)
            K_CFG0: begin
                if (!i_cfg_en) begin
                    route_d = ROUTE_RESP; status_d = ST_CRS;
                end else if (dev_ok && fn_ok) begin
                    route_d = ROUTE_REQ;
                end else begin
                    route_d = ROUTE_RESP; status_d = ST_UR;
                end
            end
            K_CPL: begin
                if ((rid.bus == o_bus_num) && dev_ok && fn_ok) begin
                    route_d = ROUTE_CPL;
                    bad_d   = (i_cpl_status != ST_SC);
                end
            end
            K_MRD, K_IORD, K_IOWR: begin
                if (bar_hit) begin
                    route_d = ROUTE_REQ; use_bar = 1'b1;
                end else begin
                    route_d = ROUTE_RESP; status_d = ST_UR;
                end
            end
            K_MWR: begin
                if (bar_hit) begin
                    route_d = ROUTE_REQ; use_bar = 1'b1;
                end
            end
            default: route_d = ROUTE_DROP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid      <= 1'b0;
            o_route      <= ROUTE_DROP;
            o_status     <= ST_SC;
            o_bar_idx    <= '0;
            o_aperture   <= '0;
            o_bad_status <= 1'b0;
        end else begin
            o_valid <= i_hdr_valid;
            if (i_hdr_valid) begin
                o_route      <= route_d;
                o_status     <= status_d;
                o_bar_idx    <= use_bar ? bar_idx : '0;
                o_aperture   <= use_bar ? bar_ap : '0;
                o_bad_status <= bad_d;
            end
        end
    end

endmodule

// File: rtl/epr_checks.sv
module epr_checks
    import epr_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       i_hdr_valid,
    input logic [7:0] i_fmt_type,
    input logic       i_cfg_en,
    input logic       o_valid,
    input logic [1:0] o_route,
    input logic [2:0] o_status,
    input logic       o_bad_status,
    input logic [7:0] o_bus_num
);

    logic is_cfg0, is_cfg1, is_mwr;
    assign is_cfg0 = (i_fmt_type == 8'h04) || (i_fmt_type == 8'h44);
    assign is_cfg1 = (i_fmt_type == 8'h05) || (i_fmt_type == 8'h45);
    assign is_mwr  = (i_fmt_type == 8'h40) || (i_fmt_type == 8'h60);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        i_hdr_valid |=> o_valid); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !i_hdr_valid |=> !o_valid); // R1
    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(i_hdr_valid && is_cfg0 && i_cfg_en) |=> $stable(o_bus_num)); // R2
    AST_RETRY_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (i_hdr_valid && is_cfg0 && !i_cfg_en) |=> (o_route == 2'd3 && o_status == 3'b010)); // R4
    AST_TYPE1_DROP: assert property (@(posedge clk) disable iff (rst)
        (i_hdr_valid && is_cfg1) |=> (o_route == 2'd2)); // R5
    AST_BAD_ONLY_CPL: assert property (@(posedge clk) disable iff (rst)
        (o_valid && o_bad_status) |-> (o_route == 2'd1)); // R6
    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (i_hdr_valid && is_mwr) |=> (o_route != 2'd3)); // R9

endmodule

bind ep_rx_router epr_checks u_chk (
    .clk          (clk),
    .rst          (rst),
    .i_hdr_valid  (i_hdr_valid),
    .i_fmt_type   (i_fmt_type),
    .i_cfg_en     (i_cfg_en),
    .o_valid      (o_valid),
    .o_route      (o_route),
    .o_status     (o_status),
    .o_bad_status (o_bad_status),
    .o_bus_num    (o_bus_num)
);

// File: tb/tb_ep_rx_router.sv
module tb_ep_rx_router;

    localparam int NB = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          i_hdr_valid = 1'b0;
    logic [7:0]    i_fmt_type = '0;
    logic [15:0]   i_rid = '0;
    logic [63:0]   i_addr = '0;
    logic [2:0]    i_cpl_status = '0;
    logic          i_cfg_en = 1'b1;
    logic [4:0]    i_dev_num = 5'd3;
    logic [32*NB-1:0] i_bar_base;
    logic [32*NB-1:0] i_bar_mask;
    logic          o_valid;
    logic [1:0]    o_route;
    logic [2:0]    o_status;
    logic [2:0]    o_bar_idx;
    logic [6:0]    o_aperture;
    logic          o_bad_status;
    logic [7:0]    o_bus_num;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    // BAR0 mem32 0x8000_0000/4K, BAR1 io 0x1000/256, BAR2+3 mem64 0x1_0000_0000/1M,
    // BAR4 mem32 0x8000_0000/1M, BAR5 unimplemented (mask 0)
    assign i_bar_base = {32'h9000_0000, 32'h8000_0000, 32'h0000_0001,
                         32'h0000_0004, 32'h0000_1001, 32'h8000_0000};
    assign i_bar_mask = {32'h0000_0000, 32'hFFF0_0000, 32'hFFFF_FFFF,
                         32'hFFF0_0000, 32'hFFFF_FF00, 32'hFFFF_F000};

    ep_rx_router #(.NUM_BARS(NB), .NUM_FUNC(2)) dut (.*);

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] ft, input logic [15:0] rid,
                        input logic [63:0] a, input logic [2:0] st);
        @(negedge clk);
        i_fmt_type = ft; i_rid = rid; i_addr = a; i_cpl_status = st;
        i_hdr_valid = 1'b1;
        @(negedge clk);
        i_hdr_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "valid after reset", o_valid, 0);
        chk("R1", "bus after reset", o_bus_num, 0);
    endtask

    task automatic t_latency();
        send(8'h04, {8'h5A, 5'd3, 3'd0}, 0, 0);
        chk("R1", "valid one cycle later", o_valid, 1);
        @(negedge clk);
        chk("R1", "valid drops", o_valid, 0);
    endtask

    task automatic t_config();
        i_cfg_en = 1'b1;
        send(8'h04, {8'h5A, 5'd3, 3'd0}, 0, 0);
        chk("R2", "cfg0 route", o_route, 0);
        chk("R2", "bus learned", o_bus_num, 8'h5A);
        send(8'h44, {8'h22, 5'd4, 3'd0}, 0, 0);
        chk("R3", "dev mismatch route", o_route, 3);
        chk("R3", "dev mismatch status", o_status, 3'b001);
        chk("R2", "bus kept on dev mismatch", o_bus_num, 8'h5A);
        send(8'h04, {8'h66, 5'd3, 3'd5}, 0, 0);
        chk("R3", "fn mismatch route", o_route, 3);
        chk("R3", "fn mismatch status", o_status, 3'b001);
        chk("R2", "bus learned on dev match", o_bus_num, 8'h66);
        i_cfg_en = 1'b0;
        send(8'h04, {8'h77, 5'd3, 3'd0}, 0, 0);
        chk("R4", "disabled route", o_route, 3);
        chk("R4", "disabled status", o_status, 3'b010);
        chk("R4", "bus kept while disabled", o_bus_num, 8'h66);
        i_cfg_en = 1'b1;
        send(8'h05, {8'h66, 5'd3, 3'd0}, 0, 0);
        chk("R5", "type1 read dropped", o_route, 2);
        send(8'h45, {8'h66, 5'd3, 3'd0}, 0, 0);
        chk("R5", "type1 write dropped", o_route, 2);
        chk("R2", "bus kept on type1", o_bus_num, 8'h66);
    endtask

    task automatic t_completion();
        send(8'h4A, {8'h66, 5'd3, 3'd1}, 0, 3'd0);
        chk("R6", "cpl claimed", o_route, 1);
        chk("R6", "good status", o_bad_status, 0);
        send(8'h0A, {8'h66, 5'd3, 3'd0}, 0, 3'd2);
        chk("R6", "cpl claimed bad", o_route, 1);
        chk("R6", "bad status flagged", o_bad_status, 1);
        send(8'h4B, {8'h11, 5'd3, 3'd0}, 0, 3'd0);
        chk("R7", "bus mismatch dropped", o_route, 2);
        send(8'h0A, {8'h66, 5'd4, 3'd0}, 0, 3'd0);
        chk("R7", "dev mismatch dropped", o_route, 2);
        send(8'h0B, {8'h66, 5'd3, 3'd6}, 0, 3'd0);
        chk("R7", "fn mismatch dropped", o_route, 2);
    endtask

    task automatic t_bar_hit();
        send(8'h00, 16'h0, 64'h8000_0010, 0);
        chk("R8", "overlap route", o_route, 0);
        chk("R8", "lowest index wins", o_bar_idx, 0);
        chk("R10", "4K aperture", o_aperture, 12);
        send(8'h20, 16'h0, 64'h8001_0000, 0);
        chk("R8", "second bar idx", o_bar_idx, 4);
        chk("R10", "1M aperture", o_aperture, 20);
        send(8'h02, 16'h0, 64'h1010, 0);
        chk("R8", "io route", o_route, 0);
        chk("R8", "io bar idx", o_bar_idx, 1);
        chk("R10", "io aperture", o_aperture, 8);
        send(8'h60, 16'h0, 64'h1_0000_0040, 0);
        chk("R11", "64-bit bar route", o_route, 0);
        chk("R11", "64-bit bar idx", o_bar_idx, 2);
        chk("R10", "64-bit aperture", o_aperture, 20);
    endtask

    task automatic t_bar_miss();
        send(8'h00, 16'h0, 64'h1010, 0);
        chk("R8", "mem read vs io bar", o_route, 3);
        chk("R9", "mem read miss status", o_status, 3'b001);
        send(8'h42, 16'h0, 64'h8000_0010, 0);
        chk("R8", "io write vs mem bar", o_route, 3);
        send(8'h02, 16'h0, 64'h0, 0);
        chk("R11", "upper half not matched", o_route, 3);
        send(8'h20, 16'h0, 64'h40, 0);
        chk("R11", "upper address bits compared", o_route, 3);
        send(8'h40, 16'h0, 64'h9000_0000, 0);
        chk("R9", "write miss dropped", o_route, 2);
        send(8'h20, 16'h0, 64'h9000_0000, 0);
        chk("R8", "zero-mask bar ignored", o_route, 3);
        chk("R9", "read miss status", o_status, 3'b001);
    endtask

    task automatic t_other();
        send(8'h30, {8'h66, 5'd3, 3'd0}, 0, 0);
        chk("R12", "unknown type dropped", o_route, 2);
        chk("R12", "bus kept", o_bus_num, 8'h66);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_latency();
        t_config();
        t_completion();
        t_bar_hit();
        t_bar_miss();
        t_other();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule